// File: doc/BRIEF.md
# Two-Wire Bus Memory Target

This block is the target side of a two-wire serial bus, placed in front of a byte-wide on-chip RAM. It oversamples the clock and data lines in the system clock domain and passes each through a synchronizer. It then finds start and stop conditions and edges on the synchronized copies. The only thing it drives onto the line is a pull-low enable for the open-drain data pin.

A host addresses the block with a selector byte. That byte has a fixed four-bit prefix, three bits that must equal the strap inputs, and a direction bit. For a write, two word-address bytes follow and then any number of data bytes. For a read, data comes from an internal address pointer that keeps its value between transactions. Current-address reads, random reads (an address-only write followed by a repeated start) and sequential reads are all served. Write data wraps inside a page. Read data wraps across the whole array.

The committing of data to nonvolatile storage is handled by a separate engine. That engine reports a busy flag, and this block refuses to acknowledge while the flag is set.

Top module: `tw_mem_target`

## Requirements
- R1: After reset the data-line enable is low, and the address pointer is 0. A current-address read issued right after reset therefore returns the byte stored at address 0.
- R2: The selector byte (MSB first) is acknowledged only if bits 7..4 equal 1010 and bits 3..1 equal `strap_i`. Otherwise the block gives no acknowledge, ignores every byte until the next start, and leaves memory unchanged.
- R3: While `wr_busy_i` is high, a selector byte that would otherwise match is not acknowledged.
- R4: Bit 0 of the selector is 0 for a write. After a write selector, the block acknowledges a high word-address byte and then a low one. Only the low ADDR_W bits of the resulting 16-bit value are kept. Each data byte that follows is acknowledged and stored.
- R5: During a write, the address advances only within its 2^PAGE_W-byte page. After the last byte of the page, the next byte is stored at the first byte of the same page.
- R6: After any access, the pointer holds the last accessed address plus one, using the same wrap rule as that access. A read selector (bit 0 = 1) with no preceding address phase returns the byte at the pointer.
- R7: A write selector, two address bytes, a repeated start and a read selector together return the byte at the address just loaded.
- R8: In a read, each host acknowledge (data low in the ninth clock) makes the block send the next byte. Read addresses wrap from 2^ADDR_W-1 to 0.
- R9: When the host does not acknowledge a read byte, the block releases the data line and drives nothing more until the next start.
- R10: A start or stop that arrives in the middle of a byte abandons that byte without storing it. A start always returns the block to the selector phase.
- R11: The data-line enable changes only while the synchronized clock line is low. Output bits hold steady for the whole high phase of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, sampled asynchronously |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Board-set selector bits compared with selector bits 3..1 |
| wr_busy_i | input | 1 | Commit engine busy; blocks acknowledge |
| sda_oe_o | output | 1 | When high, the data line is pulled low |

## Verification
A corrupted pointer or page counter appears at the ports within one byte time: the next read returns a byte from the wrong location, and the bench compares every such byte against an arithmetic pattern model. A wrong protocol state appears within a single bit time as a missing or stray acknowledge, or as the data line being held low after a host no-acknowledge. Mid-byte aborts and strap mismatches are followed by read-back of the target location, so a write that should not have happened becomes visible at the next read.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } tw_state_e;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    // synchronized bus view handed from the line front end to the protocol engine
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } tw_line_t;

    function automatic logic sel_hit(input logic [7:0] sel, input logic [2:0] strap);
        return (sel[7:4] == SEL_PREFIX) && (sel[3:1] == strap);
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync
    import tw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output tw_line_t line_o
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    // idle bus is high on both lines: reset to that so no false edge appears
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_now = scl_p[STAGES-1];
    assign sda_now = sda_p[STAGES-1];

    assign line_o.scl      = scl_now;
    assign line_o.sda      = sda_now;
    assign line_o.scl_rise = scl_now & ~scl_d;
    assign line_o.scl_fall = ~scl_now & scl_d;
    assign line_o.start    = scl_now & scl_d & sda_d & ~sda_now;
    assign line_o.stop     = scl_now & scl_d & ~sda_d & sda_now;

endmodule

// File: rtl/tw_sram.sv
module tw_sram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tw_proto.sv
module tw_proto
    import tw_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  tw_line_t      line_i,
    input  logic [2:0]    strap_i,
    input  logic          busy_i,
    output logic          sda_oe_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_waddr_o,
    output logic [7:0]    mem_wdata_o,
    output logic [AW-1:0] mem_raddr_o,
    input  logic [7:0]    mem_rdata_i
);

    localparam int HI_W  = AW - 8;
    localparam int CNT_W = $clog2(9);

    tw_state_e        state;
    tw_state_e        nstate;
    logic             in_ack;
    logic             mack;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic [6:0]       tx;
    logic [AW-1:0]    ptr;
    logic [HI_W-1:0]  addr_hi;
    logic             oe;

    function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
        return {a[AW-1:PW], a[PW-1:0] + 1'b1};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            nstate      <= ST_IDLE;
            in_ack      <= 1'b0;
            mack        <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            tx          <= '0;
            ptr         <= '0;
            addr_hi     <= '0;
            oe          <= 1'b0;
            mem_we_o    <= 1'b0;
            mem_waddr_o <= '0;
            mem_wdata_o <= '0;
        end else begin
            mem_we_o <= 1'b0;
            if (line_i.start) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                oe      <= 1'b0;
            end else if (line_i.stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                oe      <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (line_i.scl_rise) begin
                    if (!in_ack) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (state != ST_RD) begin
                            shreg <= {shreg[6:0], line_i.sda};
                        end
                    end else if (state == ST_RD) begin
                        mack <= ~line_i.sda;
                    end
                end else if (line_i.scl_fall) begin
                    if (!in_ack) begin
                        if (state == ST_RD) begin
                            if (bit_cnt == CNT_W'(8)) begin
                                oe     <= 1'b0;
                                in_ack <= 1'b1;
                            end else begin
                                oe <= ~tx[6];
                                tx <= {tx[5:0], 1'b0};
                            end
                        end else if (bit_cnt == CNT_W'(8)) begin
                            unique case (state)
                                ST_DEV: begin
                                    if (sel_hit(shreg, strap_i) && !busy_i) begin
                                        oe     <= 1'b1;
                                        in_ack <= 1'b1;
                                        nstate <= shreg[0] ? ST_RD : ST_AHI;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_AHI: begin
                                    oe      <= 1'b1;
                                    in_ack  <= 1'b1;
                                    addr_hi <= shreg[HI_W-1:0];
                                    nstate  <= ST_ALO;
                                end
                                ST_ALO: begin
                                    oe     <= 1'b1;
                                    in_ack <= 1'b1;
                                    ptr    <= {addr_hi, shreg};
                                    nstate <= ST_WR;
                                end
                                default: begin
                                    oe          <= 1'b1;
                                    in_ack      <= 1'b1;
                                    mem_we_o    <= 1'b1;
                                    mem_waddr_o <= ptr;
                                    mem_wdata_o <= shreg;
                                    ptr         <= page_next(ptr);
                                    nstate      <= ST_WR;
                                end
                            endcase
                        end
                    end else begin
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        if (nstate == ST_RD && (state != ST_RD || mack)) begin
                            state <= ST_RD;
                            tx    <= mem_rdata_i[6:0];
                            oe    <= ~mem_rdata_i[7];
                            ptr   <= ptr + 1'b1;
                        end else if (state == ST_RD) begin
                            state <= ST_IDLE;
                            oe    <= 1'b0;
                        end else begin
                            state <= nstate;
                            oe    <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign sda_oe_o    = oe;
    assign mem_raddr_o = ptr;

    // R11: the line enable only moves while the bus clock is low
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe) |-> !line_i.scl);

    // R1: nothing is driven while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !oe);

    // R2: a selector acknowledge needs a matching prefix and strap
    p_ack_match_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && oe) |-> sel_hit(shreg, strap_i));

    // R3: no selector acknowledge starts while the commit engine is busy
    p_busy_no_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DEV && $rose(oe)) |-> !$past(busy_i));

    // R10: a start always lands in the selector phase with the line free
    p_start_rearm_r10: assert property (@(posedge clk) disable iff (rst)
        line_i.start |=> (state == ST_DEV && !oe && !in_ack));

    // R9: the host's acknowledge slot of a read is never driven
    p_mack_release_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && in_ack) |-> !oe);

endmodule

// File: rtl/tw_mem_target.sv
module tw_mem_target
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wr_busy_i,
    output logic       sda_oe_o
);

    tw_line_t          line;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_rdata;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .line_o (line)
    );

    tw_proto #(.AW(ADDR_W), .PW(PAGE_W)) u_proto (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .strap_i     (strap_i),
        .busy_i      (wr_busy_i),
        .sda_oe_o    (sda_oe_o),
        .mem_we_o    (mem_we),
        .mem_waddr_o (mem_waddr),
        .mem_wdata_o (mem_wdata),
        .mem_raddr_o (mem_raddr),
        .mem_rdata_i (mem_rdata)
    );

    tw_sram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/tw_mem_target_tb.sv
module tw_mem_target_tb;

    localparam int       Q     = 4;
    localparam int       DEPTH = 2048;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'hA, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'hA, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_ptr = 0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    tw_mem_target u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .strap_i   (STRAP),
        .wr_busy_i (busy),
        .sda_oe_o  (sda_oe)
    );

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s_a, output logic s_b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(Q);
        s_a = sda_bus; tick(Q - 1);
        s_b = sda_bus; tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a, b;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], a, b);
        clk_bit(1'b1, a, b);
        ack = ~a;
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        logic a, b;
        for (int i = 7; i > 7 - n; i--) clk_bit(d[i], a, b);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic a, b;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, a, b);
            d[i] = a;
            chk(a == b, "R11 bit steady in high phase", int'(b), int'(a));
        end
        clk_bit(~give_ack, a, b);
    endtask

    task automatic wr_page(input int a, input int n, input int seed, input string req);
        logic ack;
        int base, addr;
        base = a & ~31;
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R4 write selector ack", int'(ack), 1);
        send_byte(8'(((a >> 8) & 7) | 8'hF8), ack);
        chk(ack, "R4 high address ack", int'(ack), 1);
        send_byte(8'(a & 255), ack);
        chk(ack, "R4 low address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            addr = base | ((a + i) & 31);
            send_byte(pat(addr, seed), ack);
            chk(ack, req, int'(ack), 1);
            model[addr] = pat(addr, seed);
        end
        bus_stop();
        exp_ptr = base | ((a + n) & 31);
        tick(Q);
    endtask

    task automatic rd_rand(input int a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        int addr;
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R7 dummy write selector ack", int'(ack), 1);
        send_byte(8'((a >> 8) & 7), ack);
        chk(ack, "R7 high address ack", int'(ack), 1);
        send_byte(8'(a & 255), ack);
        chk(ack, "R7 low address ack", int'(ack), 1);
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R7 read selector ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            addr = (a + i) % DEPTH;
            recv_byte(i < n - 1, d);
            chk(d == model[addr], req, int'(d), int'(model[addr]));
        end
        bus_stop();
        exp_ptr = (a + n) % DEPTH;
        tick(Q);
    endtask

    task automatic rd_cur(input int n, input string req);
        logic ack;
        logic [7:0] d;
        int addr;
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R6 current read selector ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            addr = (exp_ptr + i) % DEPTH;
            recv_byte(i < n - 1, d);
            chk(d == model[addr], req, int'(d), int'(model[addr]));
        end
        bus_stop();
        exp_ptr = (exp_ptr + n) % DEPTH;
        tick(Q);
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk(sda_oe == 1'b0, "R1 line free after reset", int'(sda_oe), 0);

        // R4 / R5: fill eight full pages, high address byte with don't-care bits set
        for (int p = 0; p < 8; p++) wr_page(p * 32, 32, 1, "R4 data byte ack");

        // R8 / R7: read all 256 bytes back in one sequential burst
        rd_rand(0, 256, "R8 sequential read data");

        // R5: page wrap on write, starting four bytes before the page end
        wr_page(16'h05C, 6, 2, "R5 wrapping write ack");
        rd_cur(1, "R6 pointer after page-wrapped write");
        rd_rand(16'h040, 8, "R5 page wrap placement");

        // R8: read wrap from the top of the array to address 0
        wr_page(16'h7FE, 2, 3, "R4 top bytes ack");
        rd_rand(16'h7FE, 4, "R8 read wrap past last byte");

        // R2: strap mismatch and prefix mismatch
        bus_start();
        send_byte({4'hA, 3'b010, 1'b0}, ack);
        chk(!ack, "R2 strap mismatch no ack", int'(ack), 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 ignored address byte", int'(ack), 0);
        send_byte(8'h10, ack);
        chk(!ack, "R2 ignored address byte", int'(ack), 0);
        send_byte(8'h99, ack);
        chk(!ack, "R2 ignored data byte", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte({4'hB, STRAP, 1'b0}, ack);
        chk(!ack, "R2 prefix mismatch no ack", int'(ack), 0);
        bus_stop();
        rd_rand(16'h010, 1, "R2 memory untouched by foreign write");

        // R3: busy blocks acknowledge, release restores it
        busy = 1'b1;
        bus_start();
        send_byte(DEV_W, ack);
        chk(!ack, "R3 busy no ack", int'(ack), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R3 ack after busy clears", int'(ack), 1);
        bus_stop();

        // R9: no-acknowledge ends the read and frees the line
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h20, ack);
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b0, d);
        chk(d == model[32'h20], "R9 last read byte", int'(d), int'(model[32'h20]));
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R9 line released after nack", int'(d), 8'hFF);
        bus_stop();
        exp_ptr = 16'h021;
        rd_cur(1, "R9 pointer after nack read");

        // R10: stop mid data byte stores nothing
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h30, ack);
        send_bits(8'h5A, 4);
        bus_stop();
        rd_rand(16'h030, 1, "R10 stop mid byte not stored");

        // R10 / R7: repeated start mid byte goes back to selector phase
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h50, ack);
        send_bits(8'hC3, 3);
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R10 selector after mid-byte start", int'(ack), 1);
        recv_byte(1'b0, d);
        chk(d == model[32'h50], "R10 read after aborted byte", int'(d), int'(model[32'h50]));
        bus_stop();
        tick(Q);

        // R1: reset clears the pointer
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        chk(sda_oe == 1'b0, "R1 line free after second reset", int'(sda_oe), 0);
        exp_ptr = 0;
        rd_cur(1, "R1 pointer zero after reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule